// File: doc/BRIEF.md
# Multi-Format Floating-Point Flag Comparator

This unit compares two IEEE 754 values and reports the outcome as a four-bit condition nibble (N, Z, C, V) plus an invalid-operation flag. A two-bit size code selects half, single or double precision. The operands arrive on 64-bit buses, and a narrower value sits in the low bits of its bus. A with-zero select replaces the second operand with positive zero of the selected width. A signalling-compare select widens the invalid-operation condition from signalling NaNs to every NaN.

A request is a one-cycle strobe on `in_valid`. The result appears one cycle later together with a one-cycle `res_valid` pulse. The condition nibble is held until the next defined compare. A reserved size code, or half precision while half support is switched off, is reported on `undef_flag`. Such a request leaves the nibble untouched.

Top module: `fpcmp_flags`

## Requirements
- R1: Size code 01 compares bits [15:0] (5 exponent and 10 fraction bits), code 10 compares bits [31:0] (8/23), and code 11 compares bits [63:0] (11/52). Bus bits above the selected width have no effect.
- R2: Size code 00, or size code 01 while `half_ok` is 0, sets `undef_flag` with the result pulse. It keeps `inv_flag` at 0 and leaves `nzcv` at its previous value.
- R3: With `zero_sel` set, `op_b` is ignored and the first operand is compared against positive zero of the selected width.
- R4: If either operand is a NaN (exponent all ones, fraction nonzero), `nzcv` becomes 0011 (unordered).
- R5: For ordered operands, a first operand that is less than the second gives 1000, equal gives 0110 and greater gives 0010. Exactly one of these four codes (or 0011) results from every defined compare.
- R6: +0 and -0 compare equal. Infinities are ordered by sign beyond all finite values. Subnormals are ordered by magnitude together with normal values.
- R7: With `sig_cmp` set, `inv_flag` is 1 when either operand is any NaN, quiet or signalling.
- R8: With `sig_cmp` clear, `inv_flag` is 1 only when an operand is a signalling NaN (most significant fraction bit 0).
- R9: `res_valid` is high exactly in the cycle after each `in_valid` strobe, and `nzcv` is held while no defined compare completes.
- R10: Synchronous active-high reset sets `nzcv` to 0000 and clears `res_valid`, `inv_flag` and `undef_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| size_code | input | 2 | Format: 01 half, 10 single, 11 double, 00 reserved |
| zero_sel | input | 1 | Compare the first operand against +0 |
| sig_cmp | input | 1 | Raise invalid operation on any NaN |
| half_ok | input | 1 | Half precision is supported |
| op_a | input | 64 | First operand, right-aligned |
| op_b | input | 64 | Second operand, right-aligned |
| res_valid | output | 1 | Result pulse |
| nzcv | output | 4 | Held condition nibble N,Z,C,V |
| inv_flag | output | 1 | Invalid operation, valid with res_valid |
| undef_flag | output | 1 | Undefined request, valid with res_valid |

## Verification
The bench builds the block with its default 64-bit bus. It sweeps a fifteen-value catalogue in every ordered pair for all three formats and both NaN modes. The catalogue holds signed zeros, the smallest and largest subnormals, ±1, 1.5, the largest finites, infinities, quiet and signalling NaNs and a negative NaN. Garbage is placed above the narrower formats, and the with-zero sweep puts a signalling NaN on the ignored bus. These sweeps reach every ordering corner and both invalid-operation rules. Separate sequences cover the two undefined cases, flag holding between requests, and the reset state.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

    localparam int DW  = 64;
    localparam int FSW = 7;

    typedef enum logic [1:0] {
        SZ_RSVD   = 2'b00,
        SZ_HALF   = 2'b01,
        SZ_SINGLE = 2'b10,
        SZ_DOUBLE = 2'b11
    } fsize_e;

    typedef enum logic [3:0] {
        CC_LT = 4'b1000,
        CC_EQ = 4'b0110,
        CC_GT = 4'b0010,
        CC_UN = 4'b0011
    } cc_e;

    typedef struct packed {
        logic          sign;
        logic [DW-2:0] mag;
        logic          is_zero;
        logic          is_nan;
        logic          is_snan;
    } fop_t;

    function automatic logic [FSW-1:0] exp_bits(fsize_e sz);
        case (sz)
            SZ_HALF:   return FSW'(5);
            SZ_DOUBLE: return FSW'(11);
            default:   return FSW'(8);
        endcase
    endfunction

    function automatic logic [FSW-1:0] frac_bits(fsize_e sz);
        case (sz)
            SZ_HALF:   return FSW'(10);
            SZ_DOUBLE: return FSW'(52);
            default:   return FSW'(23);
        endcase
    endfunction

endpackage

// File: rtl/fpcmp_unpack.sv
module fpcmp_unpack
    import fpcmp_pkg::*;
(
    input  fsize_e        sz,
    input  logic [DW-1:0] raw,
    output fop_t          op
);
    logic [FSW-1:0] fw, ew;
    logic [DW-1:0]  fmask, emask, magmask, frac_v, exp_v, mag_v;

    always_comb begin
        fw      = frac_bits(sz);
        ew      = exp_bits(sz);
        fmask   = (DW'(1) << fw) - DW'(1);
        emask   = (DW'(1) << ew) - DW'(1);
        magmask = (DW'(1) << (fw + ew)) - DW'(1);
        frac_v  = raw & fmask;
        exp_v   = (raw >> fw) & emask;
        mag_v   = raw & magmask;

        op.sign    = |(raw & (DW'(1) << (fw + ew)));
        op.mag     = mag_v[DW-2:0];
        op.is_zero = (mag_v == '0);
        op.is_nan  = (exp_v == emask) && (frac_v != '0);
        op.is_snan = op.is_nan && ((frac_v & (DW'(1) << (fw - FSW'(1)))) == '0);
    end
endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order
    import fpcmp_pkg::*;
(
    input  fop_t a,
    input  fop_t b,
    output cc_e  cc
);
    logic mag_lt, mag_eq;

    always_comb begin
        mag_lt = a.mag < b.mag;
        mag_eq = a.mag == b.mag;
        if (a.is_nan || b.is_nan)
            cc = CC_UN;
        else if (a.is_zero && b.is_zero)
            cc = CC_EQ;
        else if (a.sign != b.sign)
            cc = a.sign ? CC_LT : CC_GT;
        else if (mag_eq)
            cc = CC_EQ;
        else if (a.sign)
            cc = mag_lt ? CC_GT : CC_LT;
        else
            cc = mag_lt ? CC_LT : CC_GT;
    end
endmodule

// File: rtl/fpcmp_flags.sv
module fpcmp_flags
    import fpcmp_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [1:0]    size_code,
    input  logic          zero_sel,
    input  logic          sig_cmp,
    input  logic          half_ok,
    input  logic [DW-1:0] op_a,
    input  logic [DW-1:0] op_b,
    output logic          res_valid,
    output logic [3:0]    nzcv,
    output logic          inv_flag,
    output logic          undef_flag
);
    localparam int NOPS = 2;

    fsize_e        sz;
    logic [DW-1:0] raw [NOPS];
    fop_t          opnd [NOPS];
    cc_e           cc;
    logic          bad_req, inv_c;

    assign sz      = fsize_e'(size_code);
    assign raw[0]  = op_a;
    assign raw[1]  = zero_sel ? '0 : op_b;
    assign bad_req = (sz == SZ_RSVD) || ((sz == SZ_HALF) && !half_ok);

    for (genvar g = 0; g < NOPS; g++) begin : g_unp
        fpcmp_unpack u_unp (
            .sz  (sz),
            .raw (raw[g]),
            .op  (opnd[g])
        );
    end

    fpcmp_order u_ord (
        .a  (opnd[0]),
        .b  (opnd[1]),
        .cc (cc)
    );

    assign inv_c = sig_cmp ? (opnd[0].is_nan  || opnd[1].is_nan)
                           : (opnd[0].is_snan || opnd[1].is_snan);

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid  <= 1'b0;
            nzcv       <= 4'b0000;
            inv_flag   <= 1'b0;
            undef_flag <= 1'b0;
        end else begin
            res_valid  <= in_valid;
            undef_flag <= in_valid && bad_req;
            inv_flag   <= in_valid && !bad_req && inv_c;
            if (in_valid && !bad_req)
                nzcv <= cc;
        end
    end

    // R9: one-cycle latency
    a_r9_pulse: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> res_valid);
    a_r9_quiet: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!res_valid && $stable(nzcv)));
    // R2: undefined request keeps flags and raises no exception
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        (in_valid && bad_req) |=> (undef_flag && !inv_flag && $stable(nzcv)));
    // R5: only the four legal codes are produced
    a_r5_legal: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !undef_flag) |->
            (nzcv == 4'b1000 || nzcv == 4'b0110 || nzcv == 4'b0010 || nzcv == 4'b0011));
    // R4: a NaN operand forces the unordered code
    a_r4_unord: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !bad_req && (opnd[0].is_nan || opnd[1].is_nan)) |=> (nzcv == 4'b0011));
    // R7/R8: an exception only ever accompanies an unordered result
    a_r8_inv_unord: assert property (@(posedge clk) disable iff (rst)
        (res_valid && inv_flag) |-> (nzcv == 4'b0011));
    // R3: second operand is a positive zero in with-zero mode
    a_r3_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && zero_sel) |-> (opnd[1].is_zero && !opnd[1].sign && !opnd[1].is_nan));
endmodule

// File: tb/fpcmp_flags_bench.sv
module fpcmp_flags_bench;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst, in_valid, zero_sel, sig_cmp, half_ok;
    logic [1:0]  size_code;
    logic [63:0] op_a, op_b;
    logic        res_valid, inv_flag, undef_flag;
    logic [3:0]  nzcv;
    int total = 0;
    int bad   = 0;

    always #(PERIOD/2) clk = ~clk;

    fpcmp_flags u_fpcmp_flags (
        .clk(clk), .rst(rst), .in_valid(in_valid), .size_code(size_code),
        .zero_sel(zero_sel), .sig_cmp(sig_cmp), .half_ok(half_ok),
        .op_a(op_a), .op_b(op_b), .res_valid(res_valid), .nzcv(nzcv),
        .inv_flag(inv_flag), .undef_flag(undef_flag)
    );

    localparam logic [63:0] JUNK = 64'hDEAD_BEEF_F00D_CAFE;

    // real-line rank of catalogue entries; NaN entries are 12..14
    function automatic int rank_of(int idx);
        case (idx)
            0, 1: return 0;
            2: return 1;   3: return -1;  4: return 2;
            5: return 3;   6: return -3;  7: return 4;
            8: return 5;   9: return -5;  10: return 6;
            11: return -6;
            default: return 99;
        endcase
    endfunction

    function automatic bit is_nan_idx(int idx);
        return idx >= 12;
    endfunction

    function automatic bit is_snan_idx(int idx);
        return idx == 13;
    endfunction

    function automatic logic [63:0] mk(int fmt, int idx);
        int ew, fw;
        logic [63:0] emax, bias, fall, fmsb, s, e, f, v;
        ew = (fmt == 1) ? 5 : (fmt == 2) ? 8 : 11;
        fw = (fmt == 1) ? 10 : (fmt == 2) ? 23 : 52;
        emax = (64'd1 << ew) - 1;
        bias = (64'd1 << (ew - 1)) - 1;
        fall = (64'd1 << fw) - 1;
        fmsb = 64'd1 << (fw - 1);
        s = 0; e = 0; f = 0;
        case (idx)
            1:  s = 1;
            2:  f = 1;
            3:  begin s = 1; f = 1; end
            4:  f = fall;
            5:  e = bias;
            6:  begin s = 1; e = bias; end
            7:  begin e = bias; f = fmsb; end
            8:  begin e = emax - 1; f = fall; end
            9:  begin s = 1; e = emax - 1; f = fall; end
            10: e = emax;
            11: begin s = 1; e = emax; end
            12: begin e = emax; f = fmsb; end
            13: begin e = emax; f = 1; end
            14: begin s = 1; e = emax; f = fmsb | 1; end
            default: ;
        endcase
        v = (s << (ew + fw)) | (e << fw) | f;
        if (fmt != 3)
            v = v | (JUNK & ~((64'd1 << (ew + fw + 1)) - 1));
        return v;
    endfunction

    task automatic check(bit ok, string req, logic [7:0] act, logic [7:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(logic [1:0] sz, logic [63:0] a, logic [63:0] b, bit zs, bit sg, bit ho);
        @(negedge clk);
        in_valid = 1; size_code = sz; op_a = a; op_b = b;
        zero_sel = zs; sig_cmp = sg; half_ok = ho;
        @(negedge clk);
        in_valid = 0;
    endtask

    task automatic run_pair(int fmt, int ia, int ib, bit zs, bit sg);
        int ra, rb, eb;
        bit anynan, anysnan, exp_inv;
        logic [3:0] exp_cc;
        eb = zs ? 0 : ib;
        ra = rank_of(ia); rb = rank_of(eb);
        anynan  = is_nan_idx(ia) || is_nan_idx(eb);
        anysnan = is_snan_idx(ia) || is_snan_idx(eb);
        if (anynan)        exp_cc = 4'b0011;
        else if (ra < rb)  exp_cc = 4'b1000;
        else if (ra == rb) exp_cc = 4'b0110;
        else               exp_cc = 4'b0010;
        exp_inv = sg ? anynan : anysnan;
        issue(2'(fmt), mk(fmt, ia), zs ? mk(fmt, 13) : mk(fmt, ib), zs, sg, 1'b1);
        // R1 R3 R4 R5 R6: condition nibble
        check(nzcv == exp_cc && res_valid && !undef_flag,
              zs ? "R3" : (anynan ? "R4" : "R5/R6/R1"), {3'b0, res_valid, nzcv}, {4'b0001, exp_cc});
        // R7 R8: invalid operation
        check(inv_flag == exp_inv, sg ? "R7" : "R8", {7'b0, inv_flag}, {7'b0, exp_inv});
    endtask

    initial begin
        #(PERIOD * 150000);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1; in_valid = 0; size_code = 0; zero_sel = 0; sig_cmp = 0;
        half_ok = 1; op_a = 0; op_b = 0;
        repeat (3) @(negedge clk);
        // R10 reset state
        check(nzcv == 4'b0000 && !res_valid && !inv_flag && !undef_flag, "R10",
              {1'b0, res_valid, inv_flag, undef_flag, nzcv}, 8'h00);
        rst = 0;
        @(negedge clk);

        for (int fmt = 1; fmt <= 3; fmt++)
            for (int sg = 0; sg < 2; sg++) begin
                for (int ia = 0; ia < 15; ia++)
                    for (int ib = 0; ib < 15; ib++)
                        run_pair(fmt, ia, ib, 1'b0, sg[0]);
                for (int ia = 0; ia < 15; ia++)
                    run_pair(fmt, ia, 0, 1'b1, sg[0]);
            end

        // R9: hold and pulse width
        issue(2'b10, mk(2, 5), mk(2, 6), 0, 0, 1);
        check(nzcv == 4'b0010, "R9", {4'b0, nzcv}, 8'h02);
        @(negedge clk);
        check(!res_valid && nzcv == 4'b0010, "R9", {3'b0, res_valid, nzcv}, 8'h02);

        // R2: reserved size code with NaN operands
        issue(2'b00, mk(2, 13), mk(2, 12), 0, 1, 1);
        check(undef_flag && res_valid && !inv_flag && nzcv == 4'b0010, "R2",
              {1'b0, res_valid, inv_flag, undef_flag, nzcv}, 8'h52);
        // R2: half precision while unsupported
        issue(2'b01, mk(1, 13), mk(1, 5), 0, 1, 0);
        check(undef_flag && !inv_flag && nzcv == 4'b0010, "R2",
              {2'b0, inv_flag, undef_flag, nzcv}, 8'h12);
        // R2: half precision supported is defined
        issue(2'b01, mk(1, 6), mk(1, 5), 0, 0, 1);
        check(!undef_flag && nzcv == 4'b1000, "R2", {3'b0, undef_flag, nzcv}, 8'h08);

        // R10: reset mid-run clears flags
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        check(nzcv == 4'b0000 && !res_valid, "R10", {3'b0, res_valid, nzcv}, 8'h00);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule